// File: doc/BRIEF.md
# Display Link Control and Status Register Bank

This block is the byte-wide register bank of a serial display-link transmitter. An I2C target front end, which lies outside this block, translates bus transactions into single-cycle register writes and combinational reads on a plain address/data port. The bank returns fixed identification and clock-limit bytes. It holds the mode bits that steer the transmitter: power state, latch edge, the two sync-pass enables, four spare bits and a two-bit deskew code. It also reflects the receiver-sense and hot-plug pins through a synchronizer.

A small state machine watches one of the two sense inputs, chosen by a source-select bit, and latches any level change into an active-low monitor flag. Software clears the flag by writing one to it. A three-bit steering field puts the flag, either raw status or a constant high onto the monitor-sense output pin.

Flag machine states: `FLG_WARM` is entered at reset and lasts SYNC_STAGES+1 cycles while the synchronizer fills, and no change is detected in it. `FLG_IDLE` means no change is pending, and the flag reads 1. `FLG_PEND` means a change was seen, and the flag reads 0. The transitions are as follows. WARM goes to IDLE when the warm-up count expires. IDLE goes to PEND when the selected source changes, and this holds even when a clear write arrives in the same cycle. PEND goes to IDLE on a clear write in a cycle with no new change. PEND stays in PEND otherwise.

Top module: `dlink_regfile`

## Requirements
- R1: Reads of addresses 0x00, 0x01, 0x02, 0x03 and 0x04 return 0x01, 0x00, 0x06, 0x00 and 0x00. These are the vendor ID low and high bytes, the device ID low and high bytes, and the revision.
- R2: Address 0x05 reads 0x20, the low clock limit in MHz. Address 0x06 reads 0x64, the high clock limit less 65 MHz. Writes to addresses 0x00 through 0x06 change nothing.
- R3: After reset, the mode register at 0x08 reads 0x0C. Its fields are bit0 power-on (0 means powered down), bit1 rising-edge-first, bit2 hsync pass, bit3 vsync pass and bits7:4 spare. The outputs mirror these fields. The sense register at 0x09 has the flag (bit2) at 1, the source select (bit3) at 0 and the pin steering (bits6:4) at 000. The deskew register at 0x0A reads 0x00.
- R4: A write to 0x08 appears on the mode outputs and in the readback from the next cycle. A write to 0x0A stores bits1:0 as the deskew code, where 00 is the default, 01 maximum hold, 10 maximum setup and 11 no effect. The other bits of 0x0A read 0.
- R5: Bit0 of 0x09 reads the receiver-sense pin and bit1 reads the hot-plug pin, each SYNC_STAGES clock edges after the pin settles. Writes to these bits change nothing.
- R6: A level change on the selected source drives the flag (bit2 of 0x09) to 0 on the (SYNC_STAGES+1)th clock edge after the pin moves. The flag then stays 0 until it is cleared.
- R7: Writing 1 to bit2 of 0x09 sets the flag back to 1 from the next cycle. Writing 0 to that bit has no effect. If a new change is detected in the same cycle as a clear write, the flag stays 0.
- R8: Source select bit3 of 0x09 picks the input: 0 for receiver-sense, 1 for hot-plug. Changes on the unselected input do not touch the flag.
- R9: Pin steering bits6:4 of 0x09 select the monitor-sense output: 000 drives it high, 001 drives the flag, 010 the synchronized receiver-sense, 011 the synchronized hot-plug. Codes 1xx drive it high.
- R10: For SYNC_STAGES+1 cycles after reset, no change is detected. A sense input held high through reset therefore leaves the flag at 1.
- R11: Unmapped addresses read 0x00, and bit7 of 0x09 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rsense_i | input | 1 | Receiver-sense pin (asynchronous) |
| hplug_i | input | 1 | Hot-plug pin (asynchronous) |
| msense_o | output | 1 | Monitor-sense output pin |
| pwr_on_o | output | 1 | 1 = normal operation, 0 = powered down |
| edge_rise_o | output | 1 | 1 = rising edge latched first |
| hsync_en_o | output | 1 | 1 = hsync passed, 0 = forced low |
| vsync_en_o | output | 1 | 1 = vsync passed, 0 = forced low |
| gp_o | output | 4 | Spare mode bits |
| deskew_o | output | 2 | Deskew code |

## Verification
The hardest case to reach is a clear write landing in exactly the cycle in which a fresh change is detected. That cycle sits SYNC_STAGES+1 edges behind the pin. The bench first makes the flag pending. It then toggles the selected pin at a known falling edge and issues the clear write so that it is captured on the (SYNC_STAGES+1)th rising edge after the toggle. A second directed case holds a sense pin high through reset to reach the warm-up path. The random phase mixes pin toggles, select changes and clear writes. After each pin toggle it waits until the synchronizer has settled.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

    localparam int A_VID_LO = 'h00;
    localparam int A_VID_HI = 'h01;
    localparam int A_DID_LO = 'h02;
    localparam int A_DID_HI = 'h03;
    localparam int A_REV    = 'h04;
    localparam int A_FLIM_L = 'h05;
    localparam int A_FLIM_H = 'h06;
    localparam int A_MODE   = 'h08;
    localparam int A_SENSE  = 'h09;
    localparam int A_DSKEW  = 'h0A;

    localparam logic [7:0] V_VID_LO = 8'h01;
    localparam logic [7:0] V_VID_HI = 8'h00;
    localparam logic [7:0] V_DID_LO = 8'h06;
    localparam logic [7:0] V_DID_HI = 8'h00;
    localparam logic [7:0] V_REV    = 8'h00;
    localparam logic [7:0] V_FLIM_L = 8'h20;
    localparam logic [7:0] V_FLIM_H = 8'h64;

    // bit positions inside the sense register
    localparam int B_RS   = 0;
    localparam int B_HP   = 1;
    localparam int B_FLAG = 2;
    localparam int B_SRC  = 3;

    typedef enum logic [1:0] {
        FLG_WARM = 2'd0,
        FLG_IDLE = 2'd1,
        FLG_PEND = 2'd2
    } flag_state_e;

    typedef enum logic [2:0] {
        PIN_OFF  = 3'b000,
        PIN_FLAG = 3'b001,
        PIN_RS   = 3'b010,
        PIN_HP   = 3'b011
    } pin_sel_e;

    typedef struct packed {
        logic [3:0] gp;
        logic       vs_en;
        logic       hs_en;
        logic       edge_rise;
        logic       pwr_on;
    } mode_t;

    localparam mode_t MODE_RST = '{gp: 4'h0, vs_en: 1'b1, hs_en: 1'b1,
                                   edge_rise: 1'b0, pwr_on: 1'b0};

endpackage

// File: rtl/dlink_sync.sv
module dlink_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dlink_chgdet.sv
module dlink_chgdet
    import dlink_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rs_s,
    input  logic hp_s,
    input  logic src_hp,
    input  logic clr_req,
    output logic flag_n
);
    localparam int CW = $clog2(STAGES + 2);

    flag_state_e state_q, state_d;
    logic [CW-1:0] warm_q;
    logic prev_rs_q, prev_hp_q;
    logic cur_sel, prev_sel, chg;

    // previous synchronized sample of both sources
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_rs_q <= 1'b0;
            prev_hp_q <= 1'b0;
        end else begin
            prev_rs_q <= rs_s;
            prev_hp_q <= hp_s;
        end
    end

    assign cur_sel  = src_hp ? hp_s : rs_s;
    assign prev_sel = src_hp ? prev_hp_q : prev_rs_q;
    assign chg      = cur_sel ^ prev_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                warm_q <= '0;
        else if (state_q == FLG_WARM) warm_q <= warm_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_WARM;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_WARM: if (warm_q == CW'(STAGES)) state_d = FLG_IDLE;
            FLG_IDLE: if (chg) state_d = FLG_PEND;
            FLG_PEND: if (clr_req && !chg) state_d = FLG_IDLE;
            default:  state_d = FLG_WARM;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FLG_PEND: flag_n = 1'b0;
            default:  flag_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/dlink_pinmux.sv
module dlink_pinmux
    import dlink_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       flag_n,
    input  logic       rs_s,
    input  logic       hp_s,
    output logic       pin
);
    always_comb begin
        unique case (sel)
            PIN_FLAG: pin = flag_n;
            PIN_RS:   pin = rs_s;
            PIN_HP:   pin = hp_s;
            default:  pin = 1'b1;   // off and reserved codes
        endcase
    end
endmodule

// File: rtl/dlink_regfile.sv
module dlink_regfile
    import dlink_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rsense_i,
    input  logic              hplug_i,
    output logic              msense_o,
    output logic              pwr_on_o,
    output logic              edge_rise_o,
    output logic              hsync_en_o,
    output logic              vsync_en_o,
    output logic [3:0]        gp_o,
    output logic [1:0]        deskew_o
);
    mode_t      mode_q;
    logic [1:0] dsk_q;
    logic       src_hp_q;
    logic [2:0] out_sel_q;
    logic       int_flag_n;
    logic [1:0] sense_s;
    logic       wr_mode, wr_sense, wr_dsk, clr_req;

    assign wr_mode  = bus_wr && (bus_addr == ADDR_W'(A_MODE));
    assign wr_sense = bus_wr && (bus_addr == ADDR_W'(A_SENSE));
    assign wr_dsk   = bus_wr && (bus_addr == ADDR_W'(A_DSKEW));
    assign clr_req  = wr_sense && bus_wdata[B_FLAG];

    dlink_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hplug_i, rsense_i}),
        .q     (sense_s)
    );

    dlink_chgdet #(.STAGES(SYNC_STAGES)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .rs_s    (sense_s[B_RS]),
        .hp_s    (sense_s[B_HP]),
        .src_hp  (src_hp_q),
        .clr_req (clr_req),
        .flag_n  (int_flag_n)
    );

    dlink_pinmux u_pin (
        .sel    (out_sel_q),
        .flag_n (int_flag_n),
        .rs_s   (sense_s[B_RS]),
        .hp_s   (sense_s[B_HP]),
        .pin    (msense_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_RST;
            dsk_q     <= 2'b00;
            src_hp_q  <= 1'b0;
            out_sel_q <= PIN_OFF;
        end else begin
            if (wr_mode) mode_q <= mode_t'(bus_wdata);
            if (wr_dsk)  dsk_q  <= bus_wdata[1:0];
            if (wr_sense) begin
                src_hp_q  <= bus_wdata[B_SRC];
                out_sel_q <= bus_wdata[6:4];
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            ADDR_W'(A_VID_LO): bus_rdata = V_VID_LO;
            ADDR_W'(A_VID_HI): bus_rdata = V_VID_HI;
            ADDR_W'(A_DID_LO): bus_rdata = V_DID_LO;
            ADDR_W'(A_DID_HI): bus_rdata = V_DID_HI;
            ADDR_W'(A_REV):    bus_rdata = V_REV;
            ADDR_W'(A_FLIM_L): bus_rdata = V_FLIM_L;
            ADDR_W'(A_FLIM_H): bus_rdata = V_FLIM_H;
            ADDR_W'(A_MODE):   bus_rdata = mode_q;
            ADDR_W'(A_SENSE):  bus_rdata = {1'b0, out_sel_q, src_hp_q,
                                            int_flag_n, sense_s};
            ADDR_W'(A_DSKEW):  bus_rdata = {6'b0, dsk_q};
            default:           bus_rdata = 8'h00;
        endcase
    end

    assign pwr_on_o    = mode_q.pwr_on;
    assign edge_rise_o = mode_q.edge_rise;
    assign hsync_en_o  = mode_q.hs_en;
    assign vsync_en_o  = mode_q.vs_en;
    assign gp_o        = mode_q.gp;
    assign deskew_o    = dsk_q;
endmodule

// File: rtl/dlink_regfile_chk.sv
module dlink_regfile_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              msense_o,
    input logic              pwr_on_o,
    input logic              flag_n,
    input logic [2:0]        out_sel
);
    logic clr_w;
    assign clr_w = bus_wr && (bus_addr == ADDR_W'(9)) && bus_wdata[2];

    assert_vid_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> (bus_rdata == 8'h01));

    assert_flim_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(6)) |-> (bus_rdata == 8'h64));

    assert_mode_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8)) |=> (pwr_on_o == $past(bus_wdata[0])));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_n && !clr_w) |=> !flag_n);

    assert_flag_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_n) |-> $past(clr_w));

    assert_pin_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b000 || out_sel[2]) |-> msense_o);

    assert_pin_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b001) |-> (msense_o == flag_n));
endmodule

bind dlink_regfile dlink_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .msense_o  (msense_o),
    .pwr_on_o  (pwr_on_o),
    .flag_n    (int_flag_n),
    .out_sel   (out_sel_q)
);

// File: tb/dlink_regfile_bench.sv
module dlink_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rsense_i = 1'b0, hplug_i = 1'b0;
    logic       msense_o, pwr_on_o, edge_rise_o, hsync_en_o, vsync_en_o;
    logic [3:0] gp_o;
    logic [1:0] deskew_o;

    int total = 0, bad = 0, cycles = 0;

    // bench model
    logic [7:0] m_mode = 8'h0C;
    logic [1:0] m_dsk = 2'b00;
    logic       m_src = 1'b0;
    logic [2:0] m_sel = 3'b000;
    logic       m_pend = 1'b0;

    dlink_regfile #(.ADDR_W(8), .SYNC_STAGES(STAGES)) u_dlink_regfile (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
        .rsense_i, .hplug_i, .msense_o, .pwr_on_o, .edge_rise_o,
        .hsync_en_o, .vsync_en_o, .gp_o, .deskew_o
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: got=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return 8'h01;
            8'h01: return 8'h00;
            8'h02: return 8'h06;
            8'h03: return 8'h00;
            8'h04: return 8'h00;
            8'h05: return 8'h20;
            8'h06: return 8'h64;
            8'h08: return m_mode;
            8'h09: return {1'b0, m_sel, m_src, ~m_pend, hplug_i, rsense_i};
            8'h0A: return {6'b0, m_dsk};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_pin();
        case (m_sel)
            3'b001:  return ~m_pend;
            3'b010:  return rsense_i;
            3'b011:  return hplug_i;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // called at a falling edge; captured at the next rising edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a == 8'h08) m_mode = d;
        if (a == 8'h0A) m_dsk = d[1:0];
        if (a == 8'h09) begin
            if (d[2]) m_pend = 1'b0;
            m_src = d[3];
            m_sel = d[6:4];
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic toggle(input logic rs, input logic hp);
        if (rs) begin rsense_i = ~rsense_i; if (!m_src) m_pend = 1'b1; end
        if (hp) begin hplug_i = ~hplug_i; if (m_src) m_pend = 1'b1; end
        tick(STAGES + 2);
    endtask

    task automatic do_reset(input logic rs_hold);
        rst_n = 1'b0; rsense_i = rs_hold; hplug_i = 1'b0;
        m_mode = 8'h0C; m_dsk = 2'b00; m_src = 1'b0; m_sel = 3'b000; m_pend = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        do_reset(1'b0);
        tick(STAGES + 3);

        // R3 reset state
        rd("R3 mode reset", 8'h08);
        rd("R3 sense reset", 8'h09);
        rd("R3 deskew reset", 8'h0A);
        chk("R3 outputs reset", {pwr_on_o, edge_rise_o, hsync_en_o, vsync_en_o, gp_o},
            8'b0011_0000);
        chk("R9 pin off at reset", {7'b0, msense_o}, 8'h01);

        // R1 / R2 constants, and writes to them ignored
        for (int a = 0; a <= 6; a++) begin
            wr(8'(a), 8'hFF);
            rd("R1 R2 constant byte", 8'(a));
        end
        // R11 unmapped
        rd("R11 unmapped 0x07", 8'h07);
        rd("R11 unmapped 0xFF", 8'hFF);

        // R4 mode and deskew
        wr(8'h08, 8'hA5);
        rd("R4 mode readback", 8'h08);
        chk("R4 mode outputs", {pwr_on_o, edge_rise_o, hsync_en_o, vsync_en_o, gp_o},
            {1'b1, 1'b0, 1'b1, 1'b0, 4'hA});
        wr(8'h0A, 8'hFE);
        rd("R4 deskew upper bits zero", 8'h0A);
        chk("R4 deskew output", {6'b0, deskew_o}, 8'h02);

        // R6 exact latency on receiver-sense, flag driven onto pin (R9)
        wr(8'h09, 8'h10);
        rsense_i = 1'b1;
        tick(STAGES);
        chk("R6 flag not yet set", {7'b0, msense_o}, 8'h01);
        tick(1);
        chk("R6 flag set on edge S+1", {7'b0, msense_o}, 8'h00);
        m_pend = 1'b1;
        tick(2);
        rd("R5 R6 sense after change", 8'h09);

        // R7 writing 0 to flag bit does nothing
        wr(8'h09, 8'h10);
        rd("R7 zero write keeps flag", 8'h09);

        // R7 clear and a new change in the same cycle: change wins
        rsense_i = 1'b0;
        tick(STAGES);
        wr(8'h09, 8'h14);
        m_pend = 1'b1;
        rd("R7 change beats clear", 8'h09);
        wr(8'h09, 8'h14);
        rd("R7 clear releases flag", 8'h09);

        // R8 unselected input ignored, selected input seen
        toggle(1'b0, 1'b1);
        rd("R8 hot-plug ignored while rsense selected", 8'h09);
        wr(8'h09, 8'h38);
        toggle(1'b1, 1'b0);
        rd("R8 rsense ignored while hot-plug selected", 8'h09);
        toggle(1'b0, 1'b1);
        rd("R8 hot-plug change seen", 8'h09);
        chk("R9 pin steered to hot-plug", {7'b0, msense_o}, {7'b0, hplug_i});

        // R9 reserved codes
        for (int c = 4; c < 8; c++) begin
            wr(8'h09, 8'(c << 4));
            chk("R9 reserved code drives high", {7'b0, msense_o}, 8'h01);
        end

        // random phase
        for (int it = 0; it < 300; it++) begin
            int unsigned r = $urandom;
            if (r[0]) toggle(r[1], r[2]);
            wr(8'($urandom_range(0, 15)), 8'($urandom));
            tick(1);
            rd("R4 R5 R6 R7 R8 random read", 8'($urandom_range(0, 15)));
            rd("R6 R8 random sense read", 8'h09);
            chk("R9 random pin", {7'b0, msense_o}, {7'b0, exp_pin()});
            chk("R4 random mode out", {pwr_on_o, edge_rise_o, hsync_en_o, vsync_en_o, gp_o},
                {m_mode[0], m_mode[1], m_mode[2], m_mode[3], m_mode[7:4]});
        end

        // R10 sense held high through reset does not set the flag
        do_reset(1'b1);
        tick(STAGES + 4);
        rd("R10 no change after warm-up", 8'h09);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule